// File: doc/BRIEF.md
# DDR3 Mode Register Command Generator

This block forms the 24-bit command word used to program one of the four DDR3 mode registers on one chip select. It then hands the word to a command port under a simple level handshake. A caller presents a register select, a chip select, a channel number and a flag that says whether the DIMM is registered, together with the timing and feature settings that belong in the mode registers. One start pulse while the block is idle captures all of these inputs. The block then raises its send line and keeps the command word steady until the port has finished with it.

Each mode register gets its own field layout inside the low address bits. The bank bits carry the register number, and the chip select sits in a separate field above them. Unbuffered DIMMs can have odd ranks whose address lines are routed mirrored. For such a rank the block exchanges the affected address and bank bits before issuing the word, so the DRAM decodes the intended value. The channel number decides which half of the mirror map applies.

Top module: `mrs_cmd_gen`

## Requirements
- R1: After a synchronous reset, `ready` is 1 and `cmd_send`, `done` and `cmd_word` are all 0.
- R2: Before any mirroring, bits 18:16 of the word hold the register number (0 to 3) and bits 22:20 hold the chip select. Bits 23, 19 and 15:13 are always 0.
- R3: Register 0 places burst control in bits 1:0, a 1 in bit 3, CAS latency in bits 6:4, a 1 in bit 8, write recovery in bits 11:9 and the fast power-down exit flag in bit 12. Bits 2 and 7 are 0.
- R4: Register 1 places drive impedance bit 1 in bit 5 and bit 0 in bit 1, and the output-disable flag in bit 12. Nominal termination bits 2, 1 and 0 go to word bits 9, 6 and 2, but only for unbuffered DIMMs. For registered DIMMs those three bits are 0.
- R5: Register 1 bit 11 is 1 only when read-strobe enable is set and bit {chip_sel[2:1], channel} of the x8 map is 1.
- R6: Register 2 places CAS write latency in bits 5:3, auto self-refresh in bit 6, extended temperature self-refresh in bit 7 and write termination in bits 10:9.
- R7: Register 3 places the MPR location in bits 1:0 and the MPR enable in bit 2. All other address bits are 0.
- R8: When mirroring applies, address bits 3/4, 5/6 and 7/8 and bank bits 16/17 are exchanged. Every other bit passes through unchanged.
- R9: Mirroring applies only to an unbuffered DIMM with an odd chip select c. The flag for c is mirror_map[c-1] on channel 0 and mirror_map[c] on channel 1. Registered DIMMs are never mirrored.
- R10: `cmd_send` rises in the cycle after start is accepted. It stays high, with `cmd_word` unchanged, until `cmd_busy` has gone high and then low again.
- R11: In the cycle after `cmd_busy` falls, `done` is high for exactly one cycle and `cmd_send` is low. `ready` is high again in the cycle after that.
- R12: A start pulse that arrives while the block is not ready is ignored. The command word and the handshake continue unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Capture inputs and begin a command (idle only) |
| reg_sel | input | 2 | Mode register number 0..3 |
| chip_sel | input | 3 | Target chip select |
| channel | input | 1 | Channel number, selects half of the mirror map |
| registered | input | 1 | 1 for registered DIMM |
| mirror_map | input | 8 | Per-chip-select mirror flags, layout per R9 |
| x8_map | input | 8 | x8 DIMM flags indexed {chip_sel[2:1], channel} |
| burst_ctl | input | 2 | Burst length/control |
| cas_lat | input | 3 | CAS latency code |
| wr_recovery | input | 3 | Write recovery code |
| pd_fast_exit | input | 1 | Precharge power-down exit mode |
| drive_imp | input | 2 | Output driver impedance code |
| rtt_nom | input | 3 | Nominal termination code |
| out_disable | input | 1 | Output disable flag |
| rdqs_enable | input | 1 | Read strobe enable (TDQS gate) |
| cas_wr_lat | input | 3 | CAS write latency code |
| auto_self_ref | input | 1 | Auto self-refresh |
| self_ref_ext | input | 1 | Extended temperature self-refresh |
| rtt_write | input | 2 | Dynamic write termination |
| mpr_loc | input | 2 | MPR location |
| mpr_enable | input | 1 | MPR enable |
| cmd_busy | input | 1 | Command port busy indication |
| cmd_word | output | 24 | Command word to the port |
| cmd_send | output | 1 | Send request, held until busy clears |
| ready | output | 1 | Idle, start will be accepted |
| done | output | 1 | One-cycle completion pulse |

## Verification
Directed cases set every field of each register to all ones, so that a misplaced field shows up as a bit in the wrong position. Registered and unbuffered DIMMs are applied to register 1 to show that termination gating follows the DIMM type. The TDQS bit is driven with x8 and x4 map entries to separate the two widths. Mirrored odd chip selects are tried on both channels, and an even chip select and a registered DIMM are tried with a full mirror map; these cases tell apart the two mask halves, the odd-rank rule and the registered override. Random words and random busy delays cover the field packing and the handshake timing, and some runs add a second start during a command to show it is ignored.

// File: rtl/mrs_pkg.sv
package mrs_pkg;

    localparam int WORD_W   = 24;
    localparam int BANK_LSB = 16;
    localparam int CS_LSB   = 20;
    localparam int CSF_W    = 3;

    typedef enum logic [1:0] {
        MRSEL_0 = 2'd0,
        MRSEL_1 = 2'd1,
        MRSEL_2 = 2'd2,
        MRSEL_3 = 2'd3
    } mr_sel_e;

    typedef enum logic [1:0] {
        ISS_IDLE,
        ISS_ARM,
        ISS_WAIT,
        ISS_DONE
    } iss_state_e;

    typedef struct packed {
        logic [1:0] burst_ctl;
        logic [2:0] cas_lat;
        logic [2:0] wr_recovery;
        logic       pd_fast_exit;
        logic [1:0] drive_imp;
        logic [2:0] rtt_nom;
        logic       out_disable;
        logic [2:0] cas_wr_lat;
        logic       auto_self_ref;
        logic       self_ref_ext;
        logic [1:0] rtt_write;
        logic [1:0] mpr_loc;
        logic       mpr_enable;
    } mr_cfg_t;

    // exchange the address/bank pairs routed crosswise on a mirrored rank
    function automatic logic [WORD_W-1:0] mirror_swap(input logic [WORD_W-1:0] w);
        logic [WORD_W-1:0] r;
        r = w;
        r[3]  = w[4];
        r[4]  = w[3];
        r[5]  = w[6];
        r[6]  = w[5];
        r[7]  = w[8];
        r[8]  = w[7];
        r[16] = w[17];
        r[17] = w[16];
        return r;
    endfunction

endpackage

// File: rtl/mrs_field_pack.sv
module mrs_field_pack
    import mrs_pkg::*;
#(
    parameter int NUM_CS = 8,
    localparam int CS_W = $clog2(NUM_CS)
) (
    input  mr_sel_e              sel,
    input  logic [CS_W-1:0]      cs,
    input  logic                 channel,
    input  logic                 registered,
    input  logic                 rdqs_enable,
    input  logic [NUM_CS-1:0]    x8_map,
    input  mr_cfg_t              cfg,
    output logic [WORD_W-1:0]    word
);
    logic [CS_W-1:0] x8_idx;
    logic            tdqs_on;

    assign x8_idx  = {cs[CS_W-1:1], channel};
    assign tdqs_on = rdqs_enable & x8_map[x8_idx];

    always_comb begin
        word = '0;
        word[BANK_LSB +: 3]   = {1'b0, sel};
        word[CS_LSB +: CSF_W] = CSF_W'(cs);
        case (sel)
            MRSEL_0: begin
                word[1:0]  = cfg.burst_ctl;
                word[3]    = 1'b1;
                word[6:4]  = cfg.cas_lat;
                word[8]    = 1'b1;
                word[11:9] = cfg.wr_recovery;
                word[12]   = cfg.pd_fast_exit;
            end
            MRSEL_1: begin
                word[5]  = cfg.drive_imp[1];
                word[1]  = cfg.drive_imp[0];
                if (!registered) begin
                    word[9] = cfg.rtt_nom[2];
                    word[6] = cfg.rtt_nom[1];
                    word[2] = cfg.rtt_nom[0];
                end
                word[11] = tdqs_on;
                word[12] = cfg.out_disable;
            end
            MRSEL_2: begin
                word[5:3]  = cfg.cas_wr_lat;
                word[6]    = cfg.auto_self_ref;
                word[7]    = cfg.self_ref_ext;
                word[10:9] = cfg.rtt_write;
            end
            default: begin
                word[1:0] = cfg.mpr_loc;
                word[2]   = cfg.mpr_enable;
            end
        endcase
    end
endmodule

// File: rtl/mrs_mirror.sv
module mrs_mirror
    import mrs_pkg::*;
#(
    parameter int NUM_CS = 8,
    localparam int CS_W = $clog2(NUM_CS)
) (
    input  logic [WORD_W-1:0]  word_in,
    input  logic [CS_W-1:0]    cs,
    input  logic               channel,
    input  logic               registered,
    input  logic [NUM_CS-1:0]  mirror_map,
    output logic [WORD_W-1:0]  word_out
);
    logic [NUM_CS-1:0] rank_flip;
    logic              swap_on;

    for (genvar g = 0; g < NUM_CS; g++) begin : g_rank
        if (g % 2 == 1) begin : g_odd
            assign rank_flip[g] = channel ? mirror_map[g] : mirror_map[g-1];
        end else begin : g_even
            assign rank_flip[g] = 1'b0;
        end
    end

    assign swap_on  = !registered && rank_flip[cs];
    assign word_out = swap_on ? mirror_swap(word_in) : word_in;

    always_comb begin
        AST_REG_NO_SWAP: assert (!registered || word_out == word_in); // R9
        AST_EVEN_NO_SWAP: assert (cs[0] || word_out == word_in); // R9
    end
endmodule

// File: rtl/mrs_issue_fsm.sv
module mrs_issue_fsm
    import mrs_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [WORD_W-1:0]  next_word,
    input  logic               cmd_busy,
    output logic [WORD_W-1:0]  cmd_word,
    output logic               cmd_send,
    output logic               ready,
    output logic               done
);
    iss_state_e state;
    logic       accept;

    assign accept   = (state == ISS_IDLE) && start;
    assign ready    = (state == ISS_IDLE);
    assign cmd_send = (state == ISS_ARM) || (state == ISS_WAIT);
    assign done     = (state == ISS_DONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ISS_IDLE;
            cmd_word <= '0;
        end else begin
            if (accept) cmd_word <= next_word;
            case (state)
                ISS_IDLE: if (start)     state <= ISS_ARM;
                ISS_ARM:  if (cmd_busy)  state <= ISS_WAIT;
                ISS_WAIT: if (!cmd_busy) state <= ISS_DONE;
                default:                 state <= ISS_IDLE;
            endcase
        end
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R11
    AST_DONE_AFTER_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (state == ISS_WAIT && !cmd_busy) |=> done); // R11
    AST_WORD_HELD: assert property (@(posedge clk) disable iff (rst)
        cmd_send |=> (!cmd_send || $stable(cmd_word))); // R10
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (!ready && start) |=> $stable(cmd_word)); // R12
endmodule

// File: rtl/mrs_cmd_gen.sv
module mrs_cmd_gen
    import mrs_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [1:0]  reg_sel,
    input  logic [2:0]  chip_sel,
    input  logic        channel,
    input  logic        registered,
    input  logic [7:0]  mirror_map,
    input  logic [7:0]  x8_map,
    input  logic [1:0]  burst_ctl,
    input  logic [2:0]  cas_lat,
    input  logic [2:0]  wr_recovery,
    input  logic        pd_fast_exit,
    input  logic [1:0]  drive_imp,
    input  logic [2:0]  rtt_nom,
    input  logic        out_disable,
    input  logic        rdqs_enable,
    input  logic [2:0]  cas_wr_lat,
    input  logic        auto_self_ref,
    input  logic        self_ref_ext,
    input  logic [1:0]  rtt_write,
    input  logic [1:0]  mpr_loc,
    input  logic        mpr_enable,
    input  logic        cmd_busy,
    output logic [23:0] cmd_word,
    output logic        cmd_send,
    output logic        ready,
    output logic        done
);
    localparam int NUM_CS = 8;

    mr_cfg_t           cfg;
    logic [WORD_W-1:0] packed_word;
    logic [WORD_W-1:0] final_word;

    assign cfg = '{
        burst_ctl:     burst_ctl,
        cas_lat:       cas_lat,
        wr_recovery:   wr_recovery,
        pd_fast_exit:  pd_fast_exit,
        drive_imp:     drive_imp,
        rtt_nom:       rtt_nom,
        out_disable:   out_disable,
        cas_wr_lat:    cas_wr_lat,
        auto_self_ref: auto_self_ref,
        self_ref_ext:  self_ref_ext,
        rtt_write:     rtt_write,
        mpr_loc:       mpr_loc,
        mpr_enable:    mpr_enable
    };

    mrs_field_pack #(.NUM_CS(NUM_CS)) u_pack (
        .sel         (mr_sel_e'(reg_sel)),
        .cs          (chip_sel),
        .channel     (channel),
        .registered  (registered),
        .rdqs_enable (rdqs_enable),
        .x8_map      (x8_map),
        .cfg         (cfg),
        .word        (packed_word)
    );

    mrs_mirror #(.NUM_CS(NUM_CS)) u_mirror (
        .word_in    (packed_word),
        .cs         (chip_sel),
        .channel    (channel),
        .registered (registered),
        .mirror_map (mirror_map),
        .word_out   (final_word)
    );

    mrs_issue_fsm u_issue (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .next_word (final_word),
        .cmd_busy  (cmd_busy),
        .cmd_word  (cmd_word),
        .cmd_send  (cmd_send),
        .ready     (ready),
        .done      (done)
    );

    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (rst)
        cmd_send |-> (cmd_word[23] == 1'b0 && cmd_word[19] == 1'b0 && cmd_word[15:13] == 3'b000)); // R2
    AST_SEND_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        $countones({cmd_send, ready, done}) == 1); // R10
endmodule

// File: tb/mrs_cmd_gen_test.sv
`timescale 1ns/1ps
module mrs_cmd_gen_test;
    logic clk = 0, rst = 1, start = 0;
    logic [1:0] reg_sel = 0;
    logic [2:0] chip_sel = 0;
    logic channel = 0, registered = 0;
    logic [7:0] mirror_map = 0, x8_map = 0;
    logic [1:0] burst_ctl = 0;
    logic [2:0] cas_lat = 0, wr_recovery = 0;
    logic pd_fast_exit = 0;
    logic [1:0] drive_imp = 0;
    logic [2:0] rtt_nom = 0;
    logic out_disable = 0, rdqs_enable = 0;
    logic [2:0] cas_wr_lat = 0;
    logic auto_self_ref = 0, self_ref_ext = 0;
    logic [1:0] rtt_write = 0, mpr_loc = 0;
    logic mpr_enable = 0, cmd_busy = 0;
    logic [23:0] cmd_word;
    logic cmd_send, ready, done;
    int checks = 0, errors = 0;

    always #10 clk = ~clk;

    mrs_cmd_gen uut (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [23:0] expect_word();
        logic [23:0] w, s;
        logic flip;
        w = 24'h0;
        w[17:16] = reg_sel;
        w[22:20] = chip_sel;
        if (reg_sel == 0) begin
            w[1:0] = burst_ctl; w[3] = 1; w[6:4] = cas_lat;
            w[8] = 1; w[11:9] = wr_recovery; w[12] = pd_fast_exit;
        end else if (reg_sel == 1) begin
            w[5] = drive_imp[1]; w[1] = drive_imp[0]; w[12] = out_disable;
            if (!registered) begin w[9] = rtt_nom[2]; w[6] = rtt_nom[1]; w[2] = rtt_nom[0]; end
            w[11] = rdqs_enable & x8_map[{chip_sel[2:1], channel}];
        end else if (reg_sel == 2) begin
            w[5:3] = cas_wr_lat; w[6] = auto_self_ref; w[7] = self_ref_ext; w[10:9] = rtt_write;
        end else begin
            w[1:0] = mpr_loc; w[2] = mpr_enable;
        end
        flip = !registered && chip_sel[0] &&
               (channel ? mirror_map[chip_sel] : mirror_map[chip_sel - 3'd1]);
        s = w;
        if (flip) begin
            s[3] = w[4]; s[4] = w[3]; s[5] = w[6]; s[6] = w[5];
            s[7] = w[8]; s[8] = w[7]; s[16] = w[17]; s[17] = w[16];
        end
        return s;
    endfunction

    function automatic string word_tag();
        if (!registered && chip_sel[0] && (mirror_map != 0)) return "R8/R9 word";
        case (reg_sel)
            2'd0: return "R3 word";
            2'd1: return "R4/R5 word";
            2'd2: return "R6 word";
            default: return "R7 word";
        endcase
    endfunction

    task automatic issue(input bit poke);
        logic [23:0] exp;
        string tag;
        int d, hold;
        exp = expect_word();
        tag = word_tag();
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
        chk("R10 send raised", cmd_send, 1);
        chk(tag, cmd_word, exp);
        chk("R2 reserved", {cmd_word[23], cmd_word[19], cmd_word[15:13]}, 0);
        if (poke) begin
            reg_sel = reg_sel + 2'd1; chip_sel = chip_sel + 3'd1; burst_ctl = ~burst_ctl;
            start = 1;
            @(negedge clk); start = 0;
            chk("R12 start ignored", cmd_word, exp);
        end
        d = $urandom % 3;
        repeat (d) @(negedge clk);
        cmd_busy = 1;
        hold = 1 + $urandom % 4;
        repeat (hold) @(negedge clk);
        chk("R10 send held", cmd_send, 1);
        chk("R10 word held", cmd_word, exp);
        cmd_busy = 0;
        @(negedge clk);
        chk("R11 done", done, 1);
        chk("R11 send low", cmd_send, 0);
        @(negedge clk);
        chk("R11 done single", done, 0);
        chk("R11 ready", ready, 1);
    endtask

    task automatic all_ones();
        burst_ctl = 3; cas_lat = 7; wr_recovery = 7; pd_fast_exit = 1;
        drive_imp = 3; rtt_nom = 7; out_disable = 1; rdqs_enable = 1;
        cas_wr_lat = 7; auto_self_ref = 1; self_ref_ext = 1; rtt_write = 3;
        mpr_loc = 3; mpr_enable = 1; x8_map = 8'hFF;
    endtask

    task automatic randomize_inputs();
        reg_sel = 2'($urandom); chip_sel = 3'($urandom); channel = 1'($urandom);
        registered = 1'($urandom); mirror_map = 8'($urandom); x8_map = 8'($urandom);
        burst_ctl = 2'($urandom); cas_lat = 3'($urandom); wr_recovery = 3'($urandom);
        pd_fast_exit = 1'($urandom); drive_imp = 2'($urandom); rtt_nom = 3'($urandom);
        out_disable = 1'($urandom); rdqs_enable = 1'($urandom); cas_wr_lat = 3'($urandom);
        auto_self_ref = 1'($urandom); self_ref_ext = 1'($urandom); rtt_write = 2'($urandom);
        mpr_loc = 2'($urandom); mpr_enable = 1'($urandom);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("R1 ready", ready, 1);
        chk("R1 send", cmd_send, 0);
        chk("R1 done", done, 0);
        chk("R1 word", cmd_word, 0);

        // every field saturated, each register, unbuffered, no mirroring
        all_ones();
        for (int r = 0; r < 4; r++) begin
            reg_sel = 2'(r); chip_sel = 3'd2; issue(0);
        end
        // registered drops nominal termination (R4)
        registered = 1; reg_sel = 1; issue(0);
        registered = 0;
        // x4 entry clears TDQS (R5)
        x8_map = 8'h00; reg_sel = 1; chip_sel = 3; channel = 1; issue(0);
        rdqs_enable = 0; x8_map = 8'hFF; issue(0);
        // MR3 all zero during init (R7)
        mpr_loc = 0; mpr_enable = 0; reg_sel = 3; chip_sel = 0; issue(0);
        // mirroring on channel 0 uses even map bits (R8, R9)
        all_ones(); reg_sel = 2; channel = 0; chip_sel = 1; mirror_map = 8'h01; issue(0);
        mirror_map = 8'h02; issue(0);
        // channel 1 uses odd map bits
        channel = 1; chip_sel = 5; mirror_map = 8'h20; reg_sel = 1; issue(0);
        mirror_map = 8'h10; issue(0);
        // even chip select and registered DIMM never mirrored
        mirror_map = 8'hFF; chip_sel = 4; reg_sel = 0; issue(0);
        chip_sel = 3; registered = 1; issue(0);
        registered = 0; issue(1);

        for (int i = 0; i < 80; i++) begin
            randomize_inputs();
            issue(i % 5 == 0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule